// File: doc/BRIEF.md
# Flash Region Lock and Security Gate

This block sits between a command source and an embedded flash command engine. It stores one protection bit per lock region and one device security bit. It decodes each incoming command. Program and erase requests aimed at unprotected memory are passed on to the flash engine. Requests that hit a protected region are dropped and raise a sticky interrupt flag. Lock, unlock and secure commands are handled locally.

A dedicated erase pin is synchronised and timed by a counter. Only a hold longer than a parameterised number of clock cycles counts. The default value is sized for a hold of more than 200 ms at 50 MHz. A qualified hold wipes every protection bit and arms the security release. The security bit then drops only when a whole-array erase completes. While the security bit is set, the `access_block` output tells the debug and fast-programming paths to refuse every access.

A lock region is a run of 2^REGION_PAGES_LOG2 consecutive pages. The default is 64 pages, so the region index is the top page-address bits.

Top module: `flash_guard`

## Requirements
- R1: Opcodes on `cmd_op` are 0 program page, 1 erase page, 2 erase whole array, 3 lock, 4 unlock, 5 secure, and 6 and 7 reserved. The region of a page is the page number shifted right by REGION_PAGES_LOG2, so with the defaults the region is `cmd_page[9:6]`. Lock sets `lock_map` bit region, and unlock clears it.
- R2: A program-page or erase-page command whose region bit is set is never forwarded (`flash_go` stays low). It completes with `cmd_done` and `cmd_abort` both high, and `irq` is high from the cycle after acceptance.
- R3: An erase-whole-array command is aborted in the same way as in R2 whenever any `lock_map` bit is set.
- R4: A program or erase that is not aborted raises `flash_go` for exactly one cycle. This is the cycle after acceptance, with `fwd_op` and `fwd_page` equal to the accepted command. `cmd_done` pulses, with `cmd_abort` low, in the cycle after `flash_ack` is sampled high.
- R5: When `erase_pin` is seen high for ERASE_HOLD consecutive synchronised samples, every `lock_map` bit is cleared. A shorter high pulse changes nothing.
- R6: The secure command sets `access_block`. No command clears it.
- R7: `access_block` falls only when an erase-whole-array command completes after a qualified erase-pin hold. A whole-array erase without such a hold leaves it set, and so does a hold without a completed erase.
- R8: `irq` stays high until a cycle with `status_rd` high clears it. A new abort in the same cycle keeps it set.
- R9: Reserved opcodes complete with `cmd_done` high and `cmd_abort` low. They do not forward and change no state.
- R10: `cmd_ready` is high only while idle. Lock, unlock, secure and reserved commands give `cmd_done` in the cycle right after acceptance. After reset `cmd_ready` is high, and `lock_map`, `irq`, `access_block` and `flash_go` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command can be accepted |
| cmd_op | input | 3 | Command opcode |
| cmd_page | input | PAGE_AW | Target page number |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_abort | output | 1 | Completion was a protection abort |
| flash_go | output | 1 | One-cycle start pulse to the flash engine |
| fwd_op | output | 3 | Opcode forwarded to the flash engine |
| fwd_page | output | PAGE_AW | Page forwarded to the flash engine |
| flash_ack | input | 1 | Flash engine finished the forwarded operation |
| erase_pin | input | 1 | Asynchronous secure-erase pin |
| lock_map | output | NUM_REGIONS | Current region protection bits |
| irq | output | 1 | Sticky protection-violation interrupt |
| status_rd | input | 1 | Status read, clears irq |
| access_block | output | 1 | Deny debug and fast-programming access |

## Verification
The assertions assume that `flash_ack` arrives only while a forwarded operation is outstanding. They also assume that `cmd_op` and `cmd_page` are stable in the accepting cycle. The bench meets both by modelling the flash engine itself: it raises `flash_ack` for one cycle, one to three cycles after it sees `flash_go`. It drives a command only when `cmd_ready` is high and holds `cmd_valid` for one accepting edge. `erase_pin` is toggled only between commands, so a wipe never coincides with a lock command.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  typedef enum logic [2:0] {
    OP_PROG   = 3'd0,
    OP_EPAGE  = 3'd1,
    OP_EALL   = 3'd2,
    OP_LOCK   = 3'd3,
    OP_UNLOCK = 3'd4,
    OP_SECURE = 3'd5,
    OP_RSV6   = 3'd6,
    OP_RSV7   = 3'd7
  } fg_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } fg_state_e;

  function automatic logic is_page_op(fg_op_e op);
    return (op == OP_PROG) || (op == OP_EPAGE);
  endfunction

  function automatic logic is_flash_op(fg_op_e op);
    return is_page_op(op) || (op == OP_EALL);
  endfunction

endpackage

// File: rtl/fg_erase_qual.sv
module fg_erase_qual #(
  parameter int unsigned HOLD = 10_000_001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic qual
);
  localparam int unsigned CW = $clog2(HOLD + 1);

  logic [1:0]    sync_q;
  logic          pin_s;
  logic [CW-1:0] cnt_q;

  assign pin_s = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], pin_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!pin_s)            cnt_q <= '0;
    else if (cnt_q != CW'(HOLD)) cnt_q <= cnt_q + 1'b1;
  end

  // fires once, on the HOLD-th consecutive high sample
  assign qual = pin_s && (cnt_q == CW'(HOLD - 1));

  AST_QUAL_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    qual |=> !qual) else $error("qualification repeated"); // R5
  AST_LOW_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_s |=> (cnt_q == '0)) else $error("counter not restarted"); // R5

endmodule

// File: rtl/fg_lock_bank.sv
module fg_lock_bank #(
  parameter int unsigned NUM_REGIONS       = 16,
  parameter int unsigned REGION_PAGES_LOG2 = 6,
  parameter int unsigned PAGE_AW           = $clog2(NUM_REGIONS) + REGION_PAGES_LOG2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   set_en,
  input  logic                   clr_en,
  input  logic                   wipe,
  input  logic [PAGE_AW-1:0]     page,
  output logic                   page_locked,
  output logic                   any_locked,
  output logic [NUM_REGIONS-1:0] lock_map
);
  localparam int unsigned RW = $clog2(NUM_REGIONS);

  function automatic logic [RW-1:0] region_of(logic [PAGE_AW-1:0] pg);
    return pg[PAGE_AW-1 -: RW];
  endfunction

  logic [RW-1:0]          sel;
  logic [NUM_REGIONS-1:0] set_vec, clr_vec, lock_q;

  assign sel = region_of(page);

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_dec
    assign set_vec[g] = set_en && (sel == RW'(g));
    assign clr_vec[g] = clr_en && (sel == RW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lock_q <= '0;
    else if (wipe) lock_q <= '0;
    else           lock_q <= (lock_q | set_vec) & ~clr_vec;
  end

  assign lock_map    = lock_q;
  assign page_locked = lock_q[sel];
  assign any_locked  = |lock_q;

  AST_WIPE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (lock_map == '0)) else $error("wipe left locks"); // R5
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !wipe) |=> lock_map[$past(sel)]) else $error("lock not set"); // R1
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !lock_map[$past(sel)]) else $error("lock not cleared"); // R1

endmodule

// File: rtl/fg_sec_ctrl.sv
module fg_sec_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic pin_qual,
  input  logic full_done,
  output logic secure,
  output logic armed
);
  logic release_ev;

  assign release_ev = armed && full_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secure <= 1'b0;
      armed  <= 1'b0;
    end else begin
      if (set_req)         secure <= 1'b1;
      else if (release_ev) secure <= 1'b0;
      if (release_ev)      armed  <= 1'b0;
      else if (pin_qual)   armed  <= 1'b1;
    end
  end

  AST_SEC_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(secure) |-> $past(set_req)) else $error("secure set without command"); // R6
  AST_SEC_RELEASE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(secure) |-> $past(armed && full_done)) else $error("secure dropped early"); // R7

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int unsigned NUM_REGIONS       = 16,
  parameter int unsigned REGION_PAGES_LOG2 = 6,
  parameter int unsigned ERASE_HOLD        = 10_000_001,
  parameter int unsigned PAGE_AW           = $clog2(NUM_REGIONS) + REGION_PAGES_LOG2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [2:0]             cmd_op,
  input  logic [PAGE_AW-1:0]     cmd_page,
  output logic                   cmd_done,
  output logic                   cmd_abort,
  output logic                   flash_go,
  output logic [2:0]             fwd_op,
  output logic [PAGE_AW-1:0]     fwd_page,
  input  logic                   flash_ack,
  input  logic                   erase_pin,
  output logic [NUM_REGIONS-1:0] lock_map,
  output logic                   irq,
  input  logic                   status_rd,
  output logic                   access_block
);
  localparam int unsigned RW = $clog2(NUM_REGIONS);

  fg_state_e          state_q;
  fg_op_e             op_in, op_q;
  logic [PAGE_AW-1:0] page_q;
  logic               abort_q, irq_q;
  logic               accept, page_locked, any_locked;
  logic               violation, pin_qual, full_done, secure, armed;

  assign op_in  = fg_op_e'(cmd_op);
  assign accept = cmd_valid && (state_q == ST_IDLE);

  // protection decision for the command in the accepting cycle
  assign violation = accept &&
                     ((is_page_op(op_in) && page_locked) ||
                      ((op_in == OP_EALL) && any_locked));

  assign full_done = (state_q == ST_WAIT) && flash_ack && (op_q == OP_EALL);

  fg_erase_qual #(.HOLD(ERASE_HOLD)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (erase_pin),
    .qual      (pin_qual)
  );

  fg_lock_bank #(
    .NUM_REGIONS       (NUM_REGIONS),
    .REGION_PAGES_LOG2 (REGION_PAGES_LOG2),
    .PAGE_AW           (PAGE_AW)
  ) u_locks (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_en      (accept && (op_in == OP_LOCK)),
    .clr_en      (accept && (op_in == OP_UNLOCK)),
    .wipe        (pin_qual),
    .page        (cmd_page),
    .page_locked (page_locked),
    .any_locked  (any_locked),
    .lock_map    (lock_map)
  );

  fg_sec_ctrl u_sec (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_req   (accept && (op_in == OP_SECURE)),
    .pin_qual  (pin_qual),
    .full_done (full_done),
    .secure    (secure),
    .armed     (armed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_PROG;
      page_q  <= '0;
      abort_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          op_q    <= op_in;
          page_q  <= cmd_page;
          abort_q <= violation;
          state_q <= (is_flash_op(op_in) && !violation) ? ST_FWD : ST_DONE;
        end
        ST_FWD:  state_q <= ST_WAIT;
        ST_WAIT: if (flash_ack) state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= violation || (irq_q && !status_rd);
  end

  assign cmd_ready    = (state_q == ST_IDLE);
  assign cmd_done     = (state_q == ST_DONE);
  assign cmd_abort    = (state_q == ST_DONE) && abort_q;
  assign flash_go     = (state_q == ST_FWD);
  assign fwd_op       = op_q;
  assign fwd_page     = page_q;
  assign irq          = irq_q;
  assign access_block = secure;

  AST_NO_FWD_LOCKED_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_go && is_page_op(fg_op_e'(fwd_op))) |-> !lock_map[fwd_page[PAGE_AW-1 -: RW]])
    else $error("locked page forwarded"); // R2
  AST_NO_FWD_LOCKED_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_go && (fg_op_e'(fwd_op) == OP_EALL)) |-> (lock_map == '0))
    else $error("erase-all with locks forwarded"); // R3
  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flash_go |=> !flash_go) else $error("go longer than one cycle"); // R4
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !status_rd) |=> irq) else $error("irq lost"); // R8
  AST_ABORT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |-> irq || $past(status_rd)) else $error("abort without irq"); // R2
  AST_DONE_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> cmd_ready) else $error("not idle after done"); // R10

endmodule

// File: tb/flash_guard_tb.sv
module flash_guard_tb_top;
  localparam int NR   = 16;
  localparam int LG   = 6;
  localparam int HOLD = 40;
  localparam int AW   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [AW-1:0] cmd_page = '0;
  logic flash_ack = 1'b0, erase_pin = 1'b0, status_rd = 1'b0;
  logic cmd_ready, cmd_done, cmd_abort, flash_go, irq, access_block;
  logic [2:0] fwd_op;
  logic [AW-1:0] fwd_page;
  logic [NR-1:0] lock_map;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [NR-1:0] mlock = '0;

  always #10 clk = ~clk;

  flash_guard #(.NUM_REGIONS(NR), .REGION_PAGES_LOG2(LG), .ERASE_HOLD(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_page(cmd_page), .cmd_done(cmd_done), .cmd_abort(cmd_abort),
    .flash_go(flash_go), .fwd_op(fwd_op), .fwd_page(fwd_page), .flash_ack(flash_ack),
    .erase_pin(erase_pin), .lock_map(lock_map), .irq(irq), .status_rd(status_rd),
    .access_block(access_block)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int region(int pg);
    return pg / 64;
  endfunction

  function automatic bit expect_abort(int op, int pg, logic [NR-1:0] lk);
    if (op == 0 || op == 1) return lk[region(pg)];
    if (op == 2) return lk != 0;
    return 0;
  endfunction

  // issue one command; returns abort flag, forward seen, cycle offsets
  task automatic issue(input int op, input int pg, output bit ab, output bit go,
                       output int go_t, output int done_t, output logic [AW-1:0] gp,
                       output logic [2:0] gop);
    int t;
    ab = 0; go = 0; go_t = -1; done_t = -1; gp = '0; gop = '0; t = 0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_page = AW'(pg);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!cmd_done && t < 100) begin
      if (flash_go && !go) begin
        go = 1; go_t = t; gp = fwd_page; gop = fwd_op;
        repeat (1 + $urandom % 3) begin @(negedge clk); t++; end
        flash_ack = 1'b1;
        @(negedge clk); t++;
        flash_ack = 1'b0;
      end else begin
        @(negedge clk); t++;
      end
    end
    if (cmd_done) begin done_t = t; ab = cmd_abort; end
  endtask

  task automatic run_cmd(string req, int op, int pg);
    bit ab, go; int gt, dt; logic [AW-1:0] gp; logic [2:0] gop; bit eab;
    eab = expect_abort(op, pg, mlock);
    issue(op, pg, ab, go, gt, dt, gp, gop);
    chk({req, " done seen"}, 32'(dt >= 0), 1);
    chk({req, " abort"}, 32'(ab), 32'(eab));
    if (op <= 2) begin
      chk({req, " R4 forward"}, 32'(go), 32'(!eab));
      if (!eab) begin
        chk("R4 go cycle", 32'(gt), 0);
        chk("R4 fwd page", 32'(gp), 32'(pg));
        chk("R4 fwd op", 32'(gop), 32'(op));
      end else begin
        chk("R2 irq after abort", 32'(irq), 1);
      end
    end else begin
      chk({req, " R10 local done next cycle"}, 32'(dt), 0);
      chk({req, " no forward"}, 32'(go), 0);
    end
    if (op == 3) mlock[region(pg)] = 1'b1;
    if (op == 4) mlock[region(pg)] = 1'b0;
    chk({req, " R1 lock_map"}, 32'(lock_map), 32'(mlock));
  endtask

  task automatic pin_hold(int n);
    @(negedge clk); erase_pin = 1'b1;
    repeat (n) @(negedge clk);
    erase_pin = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic clear_irq();
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      finished = 1;
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset ready", 32'(cmd_ready), 1);
    chk("R10 reset lock_map", 32'(lock_map), 0);
    chk("R10 reset irq", 32'(irq), 0);
    chk("R10 reset access_block", 32'(access_block), 0);
    chk("R10 reset flash_go", 32'(flash_go), 0);

    // directed corners: region edges
    run_cmd("R1 lock r0", 3, 63);
    run_cmd("R2 prog first page r0", 0, 0);
    run_cmd("R4 prog first page r1", 0, 64);
    run_cmd("R1 lock r15", 3, 1023);
    run_cmd("R2 erase page r15", 1, 960);
    run_cmd("R3 erase all locked", 2, 0);
    chk("R8 irq sticky", 32'(irq), 1);
    clear_irq();
    chk("R8 irq cleared by read", 32'(irq), 0);
    run_cmd("R9 reserved 6", 6, 5);
    run_cmd("R9 reserved 7", 7, 700);
    chk("R9 no irq", 32'(irq), 0);

    // R5 short pulse ignored, long pulse wipes
    pin_hold(HOLD - 4);
    chk("R5 short pulse no effect", 32'(lock_map), 32'(mlock));
    pin_hold(HOLD + 10);
    mlock = '0;
    chk("R5 qualified hold wipes", 32'(lock_map), 0);
    run_cmd("R5 prog after wipe", 0, 1000);

    // constrained random
    for (int i = 0; i < 300; i++) begin
      int op, pg;
      op = int'($urandom % 5);
      pg = int'({$urandom % 16, $urandom % 64}) ;
      pg = int'(($urandom % 16) * 64 + ($urandom % 64));
      run_cmd("R1/R2/R3/R4 random", op, pg);
      if ($urandom % 8 == 0) begin
        clear_irq();
        chk("R8 clear", 32'(irq), 0);
      end
    end
    clear_irq();

    // security sequence
    for (int r = 0; r < NR; r++) if (mlock[r]) run_cmd("R1 unlock", 4, r * 64);
    run_cmd("R6 secure", 5, 0);
    chk("R6 access_block set", 32'(access_block), 1);
    run_cmd("R7 erase all without pin", 2, 0);
    chk("R7 still secure", 32'(access_block), 1);
    run_cmd("R6 unlock is no clear", 4, 0);
    chk("R6 still secure", 32'(access_block), 1);
    pin_hold(HOLD + 3);
    chk("R7 hold alone keeps secure", 32'(access_block), 1);
    run_cmd("R3 lock before erase", 3, 300);
    run_cmd("R3 erase all blocked", 2, 0);
    chk("R7 aborted erase keeps secure", 32'(access_block), 1);
    run_cmd("R1 unlock again", 4, 300);
    run_cmd("R7 erase all releases", 2, 0);
    chk("R7 released", 32'(access_block), 0);
    run_cmd("R6 secure again", 5, 0);
    run_cmd("R7 erase all disarmed", 2, 0);
    chk("R7 second erase keeps secure", 32'(access_block), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    finished = 1;
    $finish;
  end
endmodule